// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter with Closing-Flag Fix-Up

This block turns a stream of payload bytes into a bit-serial HDLC line signal, one bit per clock. Between frames it sends flags (0x7E) without a break. A one-cycle start pulse arms it. At the end of the current flag it pulls bytes over a valid/ready byte interface and sends them LSB first. It then appends a frame check sequence whose width, 16 or 32 bits, is chosen per frame, and closes the frame with a flag. Inside the frame it inserts a zero after every five consecutive ones.

The stuffer does not insert a zero after a run of five ones that ends exactly on the last FCS bit. A 17-stage fix-up line at the output recognises what follows in that case: five ones, a zero, then six ones. It rewrites that sequence so that an explicit zero stands between the FCS and the closing flag. The following idle flag shares the closing flag's final zero. Because of this, the serial controller downstream never sees eleven ones that it would read as an abort. Every bit passes through the fix-up line, so the latency is constant whether or not a rewrite happens.

A frame can be cut short in two ways. The abort input can be raised, or the byte source can fail to supply a byte that the frame needs (an underrun). In both cases the transmitter sends a run of ones and then returns to flags.

Top module: `hdlc_flag_tx`

## Requirements
- R1: With no frame in progress, tx_bit repeats the flag 0x7E sent LSB first, which is the bit sequence 0,1,1,1,1,1,1,0.
- R2: While reset is held, tx_bit and in_ready are 0. Every generated bit reaches tx_bit 17 clocks after it is generated. The first bit generated after reset is bit 0 of a flag. As a result, tx_bit is 0 for the first 16 rising edges after reset release, and the flag sequence starts at edge 17.
- R3: A frame opens only after a start_i pulse. With no start pending, in_ready stays 0 whatever in_valid does. A start pulse stays pending until the first byte of a frame is accepted.
- R4: A byte transfers when in_valid and in_ready are both high at a rising edge. in_ready does not depend on in_valid. in_ready rises only in two places: in the last bit-time of a flag while a start is pending, and in the last bit-time of a payload byte that was not marked in_last. If in_valid is low at the end of a flag, another flag is sent and the frame waits.
- R5: Payload bytes are sent LSB first in the order accepted. The byte accepted with in_last high is the final payload byte.
- R6: fcs32_i is sampled when the first byte of a frame is accepted. If it is 0, the FCS is 16 bits with polynomial x^16+x^15+x^2+1. If it is 1, the FCS is 32 bits with the standard CRC-32 polynomial. In both cases the bits are processed LSB first, the register is preset to all ones, and the ones' complement of the result is sent LSB first after the last payload byte.
- R7: A zero is inserted after five consecutive ones in the payload and the FCS, except after the final FCS bit. Inserted zeros do not enter the FCS.
- R8: After the closing flag, at least one further flag is sent before the next frame's first payload bit.
- R9: Raising abort_i during payload or FCS ends the frame with ABORT_LEN consecutive ones (at least 7; 8 by default), after which flags resume. abort_i has no effect while flags are being sent.
- R10: If in_ready is high in the middle of a frame while in_valid is low, the frame ends as in R9.
- R11: The output line rewrites the 15-bit window 011111011111100 (oldest bit first) to 011111001111110. In that way a frame whose FCS ends on a run of five ones still reaches a standard receiver as a valid frame, with a zero inserted before the closing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse requesting a new frame |
| abort_i | input | 1 | Abort the frame in progress |
| fcs32_i | input | 1 | FCS width select: 0 for 16-bit, 1 for 32-bit |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Transmitter accepts the byte this cycle |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte of the frame |
| tx_bit | output | 1 | Serial line output |

## Verification
The assertions assume that start_i, abort_i and the byte interface are synchronous to clk. They also assume that a source with more payload keeps in_valid high once in_ready rises mid-frame, because a low in_valid at that moment is treated as a deliberate underrun, not as back-pressure. The stimulus changes inputs only on falling edges and keeps bytes ready during a frame. It withholds them only in the underrun case and at frame opening, where waiting is allowed. A receiver model in the bench removes inserted zeros and finds flags and aborts. A frame that the fix-up failed to repair would therefore show up as an abort, not as a delivered frame.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [1:0] {
    ST_FLAG  = 2'd0,
    ST_DATA  = 2'd1,
    ST_FCS   = 2'd2,
    ST_ABORT = 2'd3
  } tx_state_e;

  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [31:0] POLY16_REV = 32'h0000_A001;
  localparam logic [31:0] POLY32_REV = 32'hEDB8_8320;
  localparam int          RUN_LIMIT  = 5;
  localparam int          FIX_LEN    = 17;
  localparam logic [FIX_LEN-3:0] FIX_MATCH = 15'b011111011111100;
  localparam logic [FIX_LEN-3:0] FIX_REPL  = 15'b011111001111110;

endpackage

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs
  import hdlc_tx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic wide_i,
  input  logic upd_i,
  input  logic bit_i,
  input  logic shift_i,
  output logic out_o
);
  localparam logic [W-1:0] PRESET_N = W'(32'h0000_FFFF);
  localparam logic [W-1:0] PRESET_W = {W{1'b1}};

  logic [W-1:0] crc_q;
  logic [W-1:0] poly;
  logic         fb;

  assign poly  = wide_i ? W'(POLY32_REV) : W'(POLY16_REV);
  assign fb    = crc_q[0] ^ bit_i;
  assign out_o = ~crc_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n)       crc_q <= '0;
    else if (init_i)  crc_q <= wide_i ? PRESET_W : PRESET_N;
    else if (upd_i)   crc_q <= (crc_q >> 1) ^ (fb ? poly : '0);
    else if (shift_i) crc_q <= crc_q >> 1;
  end

  // R6
  preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (crc_q == ($past(wide_i) ? PRESET_W : PRESET_N)));

  // R6
  narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_i && !init_i && $past(!wide_i)) |-> (crc_q[W-1:16] == '0));

endmodule

// File: rtl/hdlc_tx_fixup.sv
module hdlc_tx_fixup
  import hdlc_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  output logic bit_o
);
  logic [FIX_LEN-1:0] line_q;
  logic               hit;

  assign hit   = (line_q[FIX_LEN-3:0] == FIX_MATCH);
  assign bit_o = line_q[FIX_LEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n)   line_q <= '0;
    else if (hit) line_q <= {line_q[FIX_LEN-2], FIX_REPL, bit_i};
    else          line_q <= {line_q[FIX_LEN-2:0], bit_i};
  end

  // R11
  fix_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

endmodule

// File: rtl/hdlc_flag_tx.sv
module hdlc_flag_tx
  import hdlc_tx_pkg::*;
#(
  parameter int ABORT_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic       fcs32_i,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       tx_bit
);
  localparam int ACW = $clog2(ABORT_LEN + 1);

  tx_state_e      state_q;
  logic [4:0]     idx_q;
  logic [7:0]     sh_q;
  logic           last_q, mode32_q, pending_q, gap_q;
  logic [2:0]     ones_q;
  logic [ACW-1:0] acnt_q;

  logic in_frame, do_abort, do_stuff, flag_end, take, raw;
  logic fcs_init, fcs_upd, fcs_shift, fcs_wide, fcs_bit;
  logic [4:0] fcs_last;

  assign in_frame = (state_q == ST_DATA) || (state_q == ST_FCS);
  assign do_abort = in_frame && abort_i;
  assign do_stuff = in_frame && !abort_i && (ones_q == 3'(RUN_LIMIT));
  assign flag_end = (state_q == ST_FLAG) && (idx_q == 5'd7);
  assign fcs_last = mode32_q ? 5'd31 : 5'd15;

  assign in_ready = (flag_end && pending_q && !gap_q) ||
                    ((state_q == ST_DATA) && !do_abort && !do_stuff &&
                     (idx_q == 5'd7) && !last_q);
  assign take     = in_ready && in_valid;

  assign fcs_init  = take && (state_q == ST_FLAG);
  assign fcs_wide  = fcs_init ? fcs32_i : mode32_q;
  assign fcs_upd   = (state_q == ST_DATA) && !do_abort && !do_stuff;
  assign fcs_shift = (state_q == ST_FCS) && !do_abort && !do_stuff;

  always_comb begin
    unique case (state_q)
      ST_FLAG: raw = FLAG_BYTE[idx_q[2:0]];
      ST_DATA: raw = sh_q[idx_q[2:0]];
      ST_FCS:  raw = fcs_bit;
      default: raw = 1'b1;
    endcase
    if (do_abort)      raw = 1'b1;
    else if (do_stuff) raw = 1'b0;
  end

  hdlc_tx_fcs #(.W(32)) u_fcs (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_i (fcs_init),
    .wide_i (fcs_wide),
    .upd_i  (fcs_upd),
    .bit_i  (raw),
    .shift_i(fcs_shift),
    .out_o  (fcs_bit)
  );

  hdlc_tx_fixup u_fix (
    .clk  (clk),
    .rst_n(rst_n),
    .bit_i(raw),
    .bit_o(tx_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      ones_q    <= '0;
    end else begin
      if (start_i)       pending_q <= 1'b1;
      else if (fcs_init) pending_q <= 1'b0;
      if (!in_frame || do_abort || do_stuff) ones_q <= '0;
      else                                   ones_q <= raw ? ones_q + 3'd1 : 3'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_FLAG;
      idx_q    <= '0;
      sh_q     <= '0;
      last_q   <= 1'b0;
      mode32_q <= 1'b0;
      gap_q    <= 1'b0;
      acnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_FLAG: begin
          idx_q <= idx_q + 5'd1;
          if (idx_q == 5'd7) begin
            idx_q <= '0;
            gap_q <= 1'b0;
            if (take) begin
              state_q  <= ST_DATA;
              sh_q     <= in_data;
              last_q   <= in_last;
              mode32_q <= fcs32_i;
            end
          end
        end
        ST_DATA, ST_FCS: begin
          if (do_abort) begin
            state_q <= ST_ABORT;
            acnt_q  <= ACW'(1);
            idx_q   <= '0;
          end else if (!do_stuff) begin
            idx_q <= idx_q + 5'd1;
            if (state_q == ST_DATA && idx_q == 5'd7) begin
              idx_q <= '0;
              if (last_q) state_q <= ST_FCS;
              else if (take) begin
                sh_q   <= in_data;
                last_q <= in_last;
              end else begin
                state_q <= ST_ABORT;
                acnt_q  <= '0;
              end
            end else if (state_q == ST_FCS && idx_q == fcs_last) begin
              idx_q   <= '0;
              state_q <= ST_FLAG;
              gap_q   <= 1'b1;
            end
          end
        end
        default: begin
          acnt_q <= acnt_q + ACW'(1);
          if (acnt_q == ACW'(ABORT_LEN - 1)) begin
            state_q <= ST_FLAG;
            idx_q   <= '0;
            gap_q   <= 1'b1;
          end
        end
      endcase
    end
  end

  // R4
  ready_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (state_q == ST_FLAG || state_q == ST_DATA));

  // R7
  stuff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !abort_i && ones_q == 3'(RUN_LIMIT)) |=> $stable(idx_q));

  // R3
  start_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> pending_q);

  // R10
  underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && in_ready && !in_valid) |=> (state_q == ST_ABORT));

  // R9
  abort_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && abort_i) |=> (state_q == ST_ABORT));

  // R8
  gap_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && $past(state_q) == ST_FLAG) |-> !$past(gap_q));

endmodule

// File: tb/hdlc_flag_tx_tb.sv
`timescale 1ns/1ps
module hdlc_flag_tx_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start_i = 1'b0, abort_i = 1'b0, fcs32_i = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready, tx_bit;
  logic [7:0] in_data = '0;

  hdlc_flag_tx u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .fcs32_i(fcs32_i), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .tx_bit(tx_bit)
  );

  int tests = 0, fails = 0, fix_hits = 0;
  bit done = 1'b0;
  logic [7:0] pay [0:63];

  // receiver model: removes inserted zeros, detects flags and aborts
  bit   rxbits [0:2047];
  logic [7:0] rx_mem [0:255];
  int rx_frames = 0, rx_aborts = 0, rx_bad = 0, rx_len = 0;
  int r_ones = 0, r_n = 0;
  bit hunt = 1'b1;

  task automatic rx_push(bit b);
    if (r_n < 2048) rxbits[r_n] = b;
    r_n++;
  endtask

  task automatic rx_close(int len);
    rx_frames++;
    rx_len = len / 8;
    if (len % 8 != 0) rx_bad++;
    for (int i = 0; i < rx_len && i < 256; i++)
      for (int j = 0; j < 8; j++) rx_mem[i][j] = rxbits[i*8+j];
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      hunt = 1'b1; r_ones = 0; r_n = 0;
    end else if (hunt) begin
      if (tx_bit) r_ones++;
      else begin
        if (r_ones == 6) begin hunt = 1'b0; r_n = 0; end
        r_ones = 0;
      end
    end else if (tx_bit) begin
      r_ones++;
      if (r_ones >= 7) begin rx_aborts++; hunt = 1'b1; r_n = 0; end
    end else begin
      if (r_ones == 6) begin
        if (r_n > 1) rx_close(r_n - 1);
        r_n = 0;
      end else begin
        for (int j = 0; j < r_ones; j++) rx_push(1'b1);
        if (r_ones != 5) rx_push(1'b0);
      end
      r_ones = 0;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fcs_of(int len, bit w);
    logic [31:0] c = w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [31:0] p = w ? 32'hEDB8_8320 : 32'h0000_A001;
    for (int i = 0; i < len; i++)
      for (int j = 0; j < 8; j++) begin
        bit fb = c[0] ^ pay[i][j];
        c = c >> 1;
        if (fb) c = c ^ p;
      end
    return w ? ~c : {16'h0, ~c[15:0]};
  endfunction

  function automatic bit ends_on_five(int len, bit w, logic [31:0] f);
    int o = 0;
    int nb = w ? 32 : 16;
    for (int i = 0; i < len*8 + nb; i++) begin
      bit b = (i < len*8) ? pay[i/8][i%8] : f[i - len*8];
      if (o == 5) o = 0;
      o = b ? o + 1 : 0;
    end
    return o == 5;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic put(logic [7:0] d, bit last);
    in_valid = 1'b1; in_data = d; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_frames(int target);
    for (int k = 0; k < 600 && rx_frames < target; k++) @(negedge clk);
  endtask

  task automatic check_last(int len, bit w, string req);
    logic [31:0] f = fcs_of(len, w);
    int nb = w ? 4 : 2;
    int bad = 0;
    for (int i = 0; i < len + nb; i++) begin
      logic [7:0] e = (i < len) ? pay[i] : 8'(f >> (8*(i-len)));
      if (rx_mem[i] !== e) bad++;
    end
    chk(rx_len == len + nb && bad == 0, req, "frame length/mismatched bytes",
        rx_len*1000 + bad, (len + nb)*1000);
  endtask

  task automatic run_frame(int len, bit w, string req);
    int f0 = rx_frames;
    if (ends_on_five(len, w, fcs_of(len, w))) fix_hits++;
    fcs32_i = w;
    pulse_start();
    for (int i = 0; i < len; i++) put(pay[i], i == len - 1);
    wait_frames(f0 + 1);
    chk(rx_frames == f0 + 1, req, "frames delivered", rx_frames - f0, 1);
    check_last(len, w, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int a0, f0, gap, bad;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk(tx_bit == 1'b0 && in_ready == 1'b0, "R2", "outputs in reset", {tx_bit, in_ready}, 0);
    rst_n = 1'b1;
    // R2 / R1: 17-clock latency, then idle flags
    bad = 0;
    for (int k = 1; k <= 40; k++) begin
      logic e;
      @(negedge clk);
      e = (k <= 16) ? 1'b0 : 8'h7E >> ((k - 17) % 8);
      if (tx_bit !== e) bad++;
    end
    chk(bad == 0, "R2", "bits off the reset/flag sequence", bad, 0);
    chk(rx_frames == 0 && rx_aborts == 0, "R1", "idle events", rx_frames + rx_aborts, 0);

    // R3: no start -> no ready
    bad = 0;
    in_valid = 1'b1; in_data = 8'hA5;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (in_ready) bad++; end
    in_valid = 1'b0;
    chk(bad == 0, "R3", "ready without start", bad, 0);

    // R9: abort while idle is ignored
    a0 = rx_aborts; f0 = rx_frames;
    abort_i = 1'b1; repeat (20) @(negedge clk); abort_i = 1'b0;
    repeat (40) @(negedge clk);
    chk(rx_aborts == a0 && rx_frames == f0, "R9", "events after idle abort",
        rx_aborts - a0 + rx_frames - f0, 0);

    // R6/R7/R11: every single-byte payload, 16-bit FCS
    for (int v = 0; v < 256; v++) begin pay[0] = 8'(v); run_frame(1, 1'b0, "R6"); end
    // R6/R7/R11: two-byte payloads, 32-bit FCS
    for (int v = 0; v < 128; v++) begin
      pay[0] = 8'(v*2+1); pay[1] = 8'(v) ^ 8'h5A; run_frame(2, 1'b1, "R6");
    end
    // R5: multi-byte frames, both widths
    for (int l = 1; l <= 24; l++) begin
      for (int i = 0; i < l; i++) pay[i] = 8'(i*37 + l*11);
      run_frame(l, l[0], "R5");
    end
    // R7: all-ones payload forces many inserted zeros
    for (int i = 0; i < 6; i++) pay[i] = 8'hFF;
    run_frame(6, 1'b0, "R7");
    // R11: the rewrite case occurred and those frames arrived intact
    chk(fix_hits > 0, "R11", "frames ending on five ones", fix_hits, 1);
    chk(rx_bad == 0, "R11", "frames with partial octets", rx_bad, 0);

    // R4: start pending, valid withheld -> flags continue, frame waits
    f0 = rx_frames; a0 = rx_aborts;
    pay[0] = 8'h3C; pay[1] = 8'hC3;
    fcs32_i = 1'b0;
    pulse_start();
    repeat (40) @(negedge clk);
    chk(rx_frames == f0 && rx_aborts == a0, "R4", "events while waiting", rx_frames - f0 + rx_aborts - a0, 0);
    put(pay[0], 1'b0); put(pay[1], 1'b1);
    wait_frames(f0 + 1);
    check_last(2, 1'b0, "R4");

    // R8: back-to-back requests keep an idle flag between frames
    f0 = rx_frames;
    pay[0] = 8'h81;
    pulse_start();
    put(pay[0], 1'b1);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    gap = 1;
    in_valid = 1'b1; in_data = pay[0]; in_last = 1'b1;
    while (!in_ready) begin @(negedge clk); gap++; end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    chk(gap >= 8 + 16 + 8, "R8", "bit-times between frames", gap, 32);
    wait_frames(f0 + 2);
    chk(rx_frames == f0 + 2, "R8", "frames delivered", rx_frames - f0, 2);
    check_last(1, 1'b0, "R8");

    // R9: abort in the middle of a frame
    f0 = rx_frames; a0 = rx_aborts;
    pulse_start();
    put(8'h12, 1'b0); put(8'h34, 1'b0);
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    repeat (80) @(negedge clk);
    chk(rx_aborts == a0 + 1 && rx_frames == f0, "R9", "aborts/frames after abort",
        (rx_aborts - a0)*10 + rx_frames - f0, 10);

    // R10: underrun mid-frame
    f0 = rx_frames; a0 = rx_aborts;
    pulse_start();
    put(8'h00, 1'b0);
    repeat (80) @(negedge clk);
    chk(rx_aborts == a0 + 1 && rx_frames == f0, "R10", "aborts/frames after underrun",
        (rx_aborts - a0)*10 + rx_frames - f0, 10);

    // R1: line returns to plain flags and still carries frames afterwards
    pay[0] = 8'hE7;
    run_frame(1, 1'b1, "R1");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule